// File: doc/BRIEF.md
# Fractional UART Baud Clock Generator

This block makes the oversampling strobe for a 16550-style serial port. It runs on a reference clock, nominally 20 MHz. The rate passes through three stages in turn. First, a coarse prescaler divides the reference by one of eight fixed factors, picked by a 3-bit code. Second, a fractional rate multiplier lets through x of every y prescaled enables. Third, the usual 16-bit divisor latch divides what is left. The tick rate is (ref / factor) × (x / y) / divisor, which is sixteen times the baud rate. With divisor 1 and y = 65000, the usual rates from 110 to 460800 baud can be reached.

Software programs the block through a plain word-addressed register port. The divisor bytes are visible only while the divisor-access bit of the line control register is set, as on a standard 16550. Any write to a rate register restarts all three stages from zero, so a new rate takes effect on a clean boundary. The outputs are two single-cycle strobes: the oversampling tick and a 1x bit strobe taken from every sixteenth tick. They are free-running pulses with no handshake, so back-pressure does not apply.

Top module: `baud_tick_gen`

## Requirements
- R1: After reset, both strobes are low. Reading offset 10 returns 4 (divide by 10), offset 11 returns 0, the line control register at offset 3 reads 0, and the divisor reads 1 once the divisor-access bit is set.
- R2: Prescaler code c at offset 10 (bits 2:0) divides the reference by 1, 2, 4, 8, 10, 12, 16 or 20 for c = 0 to 7 respectively.
- R3: The register at offset 11 holds x in bits 31:16 and y in bits 15:0. Offsets 10 and 11 read back what was written.
- R4: For a valid ratio, x consecutive tick intervals together last exactly factor × y × divisor reference cycles.
- R5: A divisor of 0 behaves as a divisor of 1.
- R6: While x is 0, or x is greater than or equal to y, no tick is produced.
- R7: Offsets 0 (low byte) and 1 (high byte) reach the divisor only while bit 7 of the line control register at offset 3 is 1. Otherwise writes to them are ignored and they read 0.
- R8: A write to the divisor bytes, offset 10 or offset 11 clears the prescaler, the accumulator and the divisor count. With factor 1, x = 1, y = 2 and divisor 1, the first tick appears on the second clock edge after the write edge.
- R9: The bit strobe pulses for one cycle, one cycle after every sixteenth tick, so its period is 16 tick periods.
- R10: When the divisor is 2 or more, a tick is never high on two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Word offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| tick_os | output | 1 | 16x oversampling tick strobe |
| tick_bit | output | 1 | 1x bit-rate strobe |

## Verification
The rate path is tested with a table of settings. The table covers every prescaler code, ratios x/y with x from 1 to 7, and divisors of 0 to 4. The span of x ticks is measured in each case, which separates a wrong factor lookup, a wrong accumulator carry and an off-by-one in the divisor. Ratios with x = 0, x = y and x > y must stay silent, which exposes a missing guard on the ratio. A write in the middle of a run, followed by an exact count of cycles to the first tick, shows whether the restart clears every stage. Writes with the divisor-access bit clear show whether the latch gating is in place.

// File: rtl/baud_gen_pkg.sv
package baud_gen_pkg;
  localparam int ADDR_W = 4;
  localparam int CODE_W = 3;
  localparam int FACT_W = 5;
  localparam int BYTE_W = 8;
  localparam int DIV_W  = 2 * BYTE_W;

  localparam logic [ADDR_W-1:0] OFF_DIV_LO = 4'd0;
  localparam logic [ADDR_W-1:0] OFF_DIV_HI = 4'd1;
  localparam logic [ADDR_W-1:0] OFF_LINE   = 4'd3;
  localparam logic [ADDR_W-1:0] OFF_PSC    = 4'd10;
  localparam logic [ADDR_W-1:0] OFF_RATIO  = 4'd11;

  localparam int                DLAB_BIT   = 7;
  localparam logic [CODE_W-1:0] PSC_RESET  = 3'd4;

  function automatic logic [FACT_W-1:0] psc_factor(input logic [CODE_W-1:0] code);
    case (code)
      3'd0:    return 5'd1;
      3'd1:    return 5'd2;
      3'd2:    return 5'd4;
      3'd3:    return 5'd8;
      3'd4:    return 5'd10;
      3'd5:    return 5'd12;
      3'd6:    return 5'd16;
      default: return 5'd20;
    endcase
  endfunction
endpackage

// File: rtl/bg_regs.sv
module bg_regs
  import baud_gen_pkg::*;
#(
  parameter int FRAC_W = 16,
  localparam int DATA_W = 2 * FRAC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [DIV_W-1:0]  div_q,
  output logic [CODE_W-1:0] code_q,
  output logic [FRAC_W-1:0] x_q,
  output logic [FRAC_W-1:0] y_q,
  output logic              dlab,
  output logic              restart
);
  logic [BYTE_W-1:0] div_lo, div_hi, line_q;
  logic              hit_lo, hit_hi, hit_psc, hit_ratio, hit_line;

  assign dlab      = line_q[DLAB_BIT];
  assign hit_lo    = we && (addr == OFF_DIV_LO) && dlab;
  assign hit_hi    = we && (addr == OFF_DIV_HI) && dlab;
  assign hit_line  = we && (addr == OFF_LINE);
  assign hit_psc   = we && (addr == OFF_PSC);
  assign hit_ratio = we && (addr == OFF_RATIO);
  assign restart   = hit_lo || hit_hi || hit_psc || hit_ratio;
  assign div_q     = {div_hi, div_lo};

  always_ff @(posedge clk) begin
    if (rst) begin
      div_lo <= 8'd1;
      div_hi <= '0;
      line_q <= '0;
      code_q <= PSC_RESET;
      x_q    <= '0;
      y_q    <= '0;
    end else begin
      if (hit_lo)    div_lo <= wdata[BYTE_W-1:0];
      if (hit_hi)    div_hi <= wdata[BYTE_W-1:0];
      if (hit_line)  line_q <= wdata[BYTE_W-1:0];
      if (hit_psc)   code_q <= wdata[CODE_W-1:0];
      if (hit_ratio) begin
        x_q <= wdata[DATA_W-1:FRAC_W];
        y_q <= wdata[FRAC_W-1:0];
      end
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      OFF_DIV_LO: if (dlab) rdata[BYTE_W-1:0] = div_lo;
      OFF_DIV_HI: if (dlab) rdata[BYTE_W-1:0] = div_hi;
      OFF_LINE:   rdata[BYTE_W-1:0] = line_q;
      OFF_PSC:    rdata[CODE_W-1:0] = code_q;
      OFF_RATIO:  rdata = {x_q, y_q};
      default:    rdata = '0;
    endcase
  end
endmodule

// File: rtl/bg_prescaler.sv
module bg_prescaler
  import baud_gen_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  input  logic [CODE_W-1:0] code,
  output logic              pre_en
);
  logic [FACT_W-1:0] cnt;
  logic [FACT_W-1:0] last;

  assign last   = psc_factor(code) - 5'd1;
  assign pre_en = (cnt == last) && !restart;

  always_ff @(posedge clk) begin
    if (rst || restart)  cnt <= '0;
    else if (cnt == last) cnt <= '0;
    else                  cnt <= cnt + 5'd1;
  end
endmodule

// File: rtl/bg_frac_acc.sv
module bg_frac_acc #(
  parameter int FRAC_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  input  logic              pre_en,
  input  logic [FRAC_W-1:0] x,
  input  logic [FRAC_W-1:0] y,
  output logic              frac_en
);
  logic [FRAC_W-1:0] acc;
  logic [FRAC_W:0]   sum;
  logic              ratio_ok, carry;

  assign ratio_ok = (x != '0) && (x < y);
  assign sum      = {1'b0, acc} + {1'b0, x};
  assign carry    = (sum >= {1'b0, y});
  assign frac_en  = pre_en && ratio_ok && carry;

  always_ff @(posedge clk) begin
    if (rst || restart) acc <= '0;
    else if (pre_en && ratio_ok) begin
      if (carry) acc <= FRAC_W'(sum - {1'b0, y});
      else       acc <= sum[FRAC_W-1:0];
    end
  end
endmodule

// File: rtl/bg_divider.sv
module bg_divider
  import baud_gen_pkg::*;
#(
  parameter int OS_RATIO = 16,
  localparam int BIT_CW = $clog2(OS_RATIO)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             frac_en,
  input  logic [DIV_W-1:0] div,
  output logic             tick_os,
  output logic             tick_bit
);
  logic [DIV_W-1:0]  dcnt;
  logic [DIV_W-1:0]  last;
  logic [BIT_CW-1:0] bcnt;

  assign last = (div == '0) ? '0 : div - 16'd1;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      dcnt    <= '0;
      tick_os <= 1'b0;
    end else begin
      tick_os <= 1'b0;
      if (frac_en) begin
        if (dcnt >= last) begin
          dcnt    <= '0;
          tick_os <= 1'b1;
        end else begin
          dcnt <= dcnt + 16'd1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      bcnt     <= '0;
      tick_bit <= 1'b0;
    end else begin
      tick_bit <= 1'b0;
      if (tick_os) begin
        if (bcnt == BIT_CW'(OS_RATIO - 1)) begin
          bcnt     <= '0;
          tick_bit <= 1'b1;
        end else begin
          bcnt <= bcnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
  import baud_gen_pkg::*;
#(
  parameter int FRAC_W   = 16,
  parameter int OS_RATIO = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  reg_we,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic [2*FRAC_W-1:0]   reg_wdata,
  output logic [2*FRAC_W-1:0]   reg_rdata,
  output logic                  tick_os,
  output logic                  tick_bit
);
  logic [DIV_W-1:0]  div_q;
  logic [CODE_W-1:0] code_q;
  logic [FRAC_W-1:0] x_q, y_q;
  logic              dlab, restart, pre_en, frac_en;

  bg_regs #(.FRAC_W(FRAC_W)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .div_q(div_q), .code_q(code_q), .x_q(x_q), .y_q(y_q),
    .dlab(dlab), .restart(restart)
  );

  bg_prescaler u_psc (
    .clk(clk), .rst(rst), .restart(restart), .code(code_q), .pre_en(pre_en)
  );

  bg_frac_acc #(.FRAC_W(FRAC_W)) u_frac (
    .clk(clk), .rst(rst), .restart(restart), .pre_en(pre_en),
    .x(x_q), .y(y_q), .frac_en(frac_en)
  );

  bg_divider #(.OS_RATIO(OS_RATIO)) u_div (
    .clk(clk), .rst(rst), .restart(restart), .frac_en(frac_en), .div(div_q),
    .tick_os(tick_os), .tick_bit(tick_bit)
  );
endmodule

// File: rtl/baud_tick_gen_chk.sv
module baud_tick_gen_chk
  import baud_gen_pkg::*;
#(
  parameter int FRAC_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              dlab,
  input logic              restart,
  input logic [DIV_W-1:0]  div_q,
  input logic [FRAC_W-1:0] x_q,
  input logic [FRAC_W-1:0] y_q,
  input logic              tick_os,
  input logic              tick_bit
);
  // R9
  bit_after_tick_chk: assert property (@(posedge clk) disable iff (rst)
    tick_bit |-> $past(tick_os));

  // R8
  restart_clears_chk: assert property (@(posedge clk) disable iff (rst)
    restart |=> !tick_os);

  // R6
  bad_ratio_silent_chk: assert property (@(posedge clk) disable iff (rst)
    ((x_q == '0) || (x_q >= y_q)) |=> !tick_os);

  // R10
  no_double_tick_chk: assert property (@(posedge clk) disable iff (rst)
    (tick_os && (div_q >= 16'd2)) |=> !tick_os);

  // R7
  latch_locked_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_we && !dlab && ((reg_addr == OFF_DIV_LO) || (reg_addr == OFF_DIV_HI)))
      |=> $stable(div_q));
endmodule

bind baud_tick_gen baud_tick_gen_chk #(.FRAC_W(FRAC_W)) u_chk (
  .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .dlab(dlab),
  .restart(restart), .div_q(div_q), .x_q(x_q), .y_q(y_q),
  .tick_os(tick_os), .tick_bit(tick_bit)
);

// File: tb/baud_tick_gen_bench.sv
module baud_tick_gen_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        tick_os, tick_bit;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  baud_tick_gen u_baud_tick_gen (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tick_os(tick_os), .tick_bit(tick_bit)
  );

  localparam int NV = 8;
  localparam int VC [NV] = '{0, 1, 4, 7, 2, 5, 6, 3};
  localparam int VX [NV] = '{1, 1, 2, 3, 5, 1, 7, 4};
  localparam int VY [NV] = '{2, 3, 5, 7, 8, 4, 9, 6};
  localparam int VD [NV] = '{1, 2, 1, 3, 4, 0, 1, 2};
  localparam int VS [NV] = '{2, 12, 50, 420, 128, 48, 144, 96};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output int v);
    @(negedge clk);
    reg_addr = a;
    #1 v = int'(reg_rdata);
  endtask

  task automatic setup(input int code, input int x, input int y, input int dv);
    wr(4'd3, 32'h80);
    wr(4'd0, 32'(dv & 8'hff));
    wr(4'd1, 32'((dv >> 8) & 8'hff));
    wr(4'd3, 32'h00);
    wr(4'd10, 32'(code));
    wr(4'd11, {16'(x), 16'(y)});
  endtask

  // cycles from one strobe to the n-th following one
  task automatic span(input bit use_bit, input int n, output int cyc);
    int c = 0;
    int seen = 0;
    do begin @(negedge clk); c++; end
    while (!(use_bit ? tick_bit : tick_os) && c < 20000);
    c = 0;
    while (seen < n && c < 20000) begin
      @(negedge clk); c++;
      if (use_bit ? tick_bit : tick_os) seen++;
    end
    cyc = c;
  endtask

  task automatic count_ticks(input int cycles, output int ticks, output int pairs);
    bit prev = 1'b0;
    ticks = 0; pairs = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (tick_os) ticks++;
      if (tick_os && prev) pairs++;
      prev = tick_os;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int v, t, p;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    @(negedge clk);
    check(!tick_os && !tick_bit, "R1 strobes low", int'(tick_os), 0);
    rd(4'd10, v); check(v == 4, "R1 prescaler code", v, 4);
    rd(4'd11, v); check(v == 0, "R1 ratio reg", v, 0);
    rd(4'd3,  v); check(v == 0, "R1 line reg", v, 0);
    wr(4'd3, 32'h80);
    rd(4'd0, v); check(v == 1, "R1 divisor low", v, 1);
    rd(4'd1, v); check(v == 0, "R1 divisor high", v, 0);
    wr(4'd3, 32'h00);

    // R2 R4 R5 rate table
    for (int i = 0; i < NV; i++) begin
      setup(VC[i], VX[i], VY[i], VD[i]);
      span(1'b0, VX[i], v);
      check(v == VS[i], (VD[i] == 0) ? "R5 zero divisor span" : "R4 R2 span", v, VS[i]);
    end

    // R3 readback
    setup(6, 7, 9, 1);
    rd(4'd11, v); check(v == 32'h0007_0009, "R3 ratio readback", v, 32'h0007_0009);
    rd(4'd10, v); check(v == 6, "R3 code readback", v, 6);

    // R6 invalid ratios
    setup(0, 0, 5, 1);
    count_ticks(2000, t, p); check(t == 0, "R6 x zero", t, 0);
    setup(0, 5, 5, 1);
    count_ticks(2000, t, p); check(t == 0, "R6 x equals y", t, 0);
    setup(0, 6, 5, 1);
    count_ticks(2000, t, p); check(t == 0, "R6 x above y", t, 0);

    // R7 divisor latch gated by access bit
    setup(0, 1, 2, 3);
    wr(4'd0, 32'h07);
    rd(4'd0, v); check(v == 0, "R7 read without access bit", v, 0);
    wr(4'd3, 32'h80);
    rd(4'd0, v); check(v == 3, "R7 write ignored", v, 3);
    wr(4'd3, 32'h00);
    span(1'b0, 1, v); check(v == 6, "R7 rate unchanged", v, 6);

    // R8 restart mid-run: divisor 3 running, then rewrite low byte to 1
    repeat (17) @(negedge clk);
    wr(4'd3, 32'h80);
    repeat (2) @(negedge clk);
    wr(4'd0, 32'h01);
    check(tick_os == 1'b0, "R8 edge+0", int'(tick_os), 0);
    @(negedge clk); check(tick_os == 1'b0, "R8 edge+1", int'(tick_os), 0);
    @(negedge clk); check(tick_os == 1'b1, "R8 edge+2", int'(tick_os), 1);
    wr(4'd3, 32'h00);

    // R9 bit strobe period
    setup(0, 1, 2, 1);
    span(1'b1, 1, v); check(v == 32, "R9 bit period fast", v, 32);
    setup(1, 1, 3, 2);
    span(1'b1, 1, v); check(v == 192, "R9 bit period slow", v, 192);

    // R10 no back-to-back ticks with divisor 2 and dense ratio
    setup(0, 3, 4, 2);
    count_ticks(600, t, p);
    check(p == 0, "R10 back-to-back ticks", p, 0);
    check(t > 100, "R10 ticks present", t, 225);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule